// File: doc/BRIEF.md
# Interrupt Number Range Remapper

This block works out where a host bridge's interrupts sit in the global interrupt number space. Its inputs are a level-interrupt source ID, which it keeps in its own write-only register, and values taken from configuration registers elsewhere: a global source ID, a compare value, a mask value, and a receive enable and a transmit enable. From these it produces a registered mapping. The mapping holds a valid flag, the first global number of the level interrupts, the base and size of the message-interrupt window, and three consistency error flags.

Both source IDs count in blocks of eight interrupts. The mapping is valid only when both enables are set and the two IDs agree. The total interrupt count is the two's complement of the mask, taken modulo 2^19. The level interrupts occupy the first slots of that range and message interrupts use the rest. The outputs are recomputed after any change to the configuration and otherwise hold their values.

Top module: `irqmap_remap`

## Requirements
- R1: While reset is asserted, and at the first sample after it, every output is 0.
- R2: When `rx_en` or `tx_en` is 0, `map_valid` is 0 and every other output is 0.
- R3: When bits [8:0] of the last written local ID differ from `glb_src_id`, `map_valid` is 0 and every other output is 0.
- R4: A write through `src_wr_en` keeps only bits [8:0] of `src_wr_data`. Bits [15:9] have no effect on the mapping.
- R5: With the mapping valid, let total = (2^19 - `irq_mask`) mod 2^19. `msg_count` is total - 8 when total >= 8, and 0 otherwise.
- R6: With the mapping valid, `lvl_base` = (`irq_cmp` + 8*`glb_src_id`) mod 2^19 and `msg_base` = `irq_cmp`.
- R7: With the mapping valid, `err_range` is 1 exactly when 8*`glb_src_id` + 8 > total.
- R8: With the mapping valid, `err_cmp` is 1 exactly when (`irq_cmp` AND `irq_mask`) != `irq_cmp`.
- R9: With the mapping valid, `err_count` is 1 exactly when total > 4096 (parameter MAX_IRQS).
- R10: A change on a configuration port shows at the outputs after exactly one rising clock edge. A local ID write shows after the second rising edge, counting the edge that captures it. With no change, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_wr_en | input | 1 | Write strobe for the local level-interrupt source ID |
| src_wr_data | input | 16 | Write data; the ID is taken from bits [8:0] |
| glb_src_id | input | 9 | Global level-interrupt source ID |
| irq_cmp | input | 19 | Interrupt number compare value (range base) |
| irq_mask | input | 19 | Interrupt number mask value |
| rx_en | input | 1 | Receive-side enable |
| tx_en | input | 1 | Transmit-side enable |
| map_valid | output | 1 | Mapping is enabled and consistent |
| lvl_base | output | 19 | First global number of the level interrupts |
| msg_base | output | 19 | First global number of the message window |
| msg_count | output | 19 | Size of the message window |
| err_range | output | 1 | Level interrupts fall outside the total count |
| err_cmp | output | 1 | Compare has bits set outside the mask |
| err_count | output | 1 | Total count exceeds the supported maximum |

## Verification
The assertions assume that every configuration port stays constant from one clock edge to the next. They relate each registered output to the input values one edge earlier, and that relation only holds if the configuration changes no faster than the output register can follow. The bench therefore changes inputs only on falling edges. It waits at least one full rising edge before it samples, and two after a local ID write. It also holds the enables and IDs steady while it sweeps the mask and compare values through the wrap, zero-count and out-of-mask cases.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  // Width of a global interrupt number
  localparam int IRQ_W = 19;

  typedef struct packed {
    logic             valid;
    logic [IRQ_W-1:0] lvl_base;
    logic [IRQ_W-1:0] msg_base;
    logic [IRQ_W-1:0] msg_count;
    logic             err_range;
    logic             err_cmp;
    logic             err_count;
  } map_res_t;

endpackage

// File: rtl/irqmap_srcid_reg.sv
module irqmap_srcid_reg #(
  parameter int WR_W    = 16,
  parameter int SRC_W   = 9,
  parameter int SRC_LSB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WR_W-1:0]  wr_data,
  output logic [SRC_W-1:0] src_id,
  output logic             wr_seen
);

  logic [SRC_W-1:0] id_q, id_d;
  logic             seen_q, seen_d;

  // Only the ID field survives a write (R4)
  always_comb begin
    id_d   = id_q;
    seen_d = wr_en;
    if (wr_en) begin
      id_d = wr_data[SRC_LSB +: SRC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      id_q   <= id_d;
      seen_q <= seen_d;
    end
  end

  assign src_id  = id_q;
  assign wr_seen = seen_q;

endmodule

// File: rtl/irqmap_change_det.sv
module irqmap_change_det #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             force_upd,
  output logic             upd
);

  logic [CFG_W-1:0] prev_q, prev_d;
  logic             diff;

  always_comb begin
    diff   = (cfg != prev_q);
    upd    = diff | force_upd;
    prev_d = upd ? cfg : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/irqmap_calc.sv
module irqmap_calc
  import irqmap_pkg::*;
#(
  parameter int SRC_W    = 9,
  parameter int NUM_LVL  = 8,
  parameter int MAX_IRQS = 4096
) (
  input  logic [SRC_W-1:0] local_id,
  input  logic [SRC_W-1:0] global_id,
  input  logic [IRQ_W-1:0] cmp,
  input  logic [IRQ_W-1:0] mask,
  input  logic             rx_en,
  input  logic             tx_en,
  output map_res_t         res
);

  localparam int SID_SH_W = SRC_W + 3;
  localparam int SUM_W    = IRQ_W + 1;

  logic [SID_SH_W-1:0] lid_s, gid_s;
  logic                enabled, ids_match, ok;
  logic [IRQ_W-1:0]    total;
  logic [SUM_W-1:0]    reach;
  logic                over_range, off_mask, too_many;
  logic [IRQ_W-1:0]    lvl_sum, msg_left;

  // IDs count in blocks of eight interrupts
  assign lid_s = {local_id, 3'b000};
  assign gid_s = {global_id, 3'b000};

  always_comb begin
    enabled    = rx_en & tx_en;
    ids_match  = (lid_s == gid_s);
    ok         = enabled & ids_match;
    total      = (~mask) + IRQ_W'(1);
    reach      = SUM_W'(gid_s) + SUM_W'(NUM_LVL);
    over_range = (reach > {1'b0, total});
    off_mask   = ((cmp & mask) != cmp);
    lvl_sum    = cmp + IRQ_W'(gid_s);
    msg_left   = (total >= IRQ_W'(NUM_LVL)) ? (total - IRQ_W'(NUM_LVL)) : '0;
  end

  // The count limit is only checked when it can be reached
  generate
    if (MAX_IRQS < (1 << IRQ_W)) begin : g_limit
      assign too_many = (total > IRQ_W'(MAX_IRQS));
    end else begin : g_nolimit
      assign too_many = 1'b0;
    end
  endgenerate

  always_comb begin
    res = '0;
    if (ok) begin
      res.valid     = 1'b1;
      res.lvl_base  = lvl_sum;
      res.msg_base  = cmp;
      res.msg_count = msg_left;
      res.err_range = over_range;
      res.err_cmp   = off_mask;
      res.err_count = too_many;
    end
  end

endmodule

// File: rtl/irqmap_remap.sv
module irqmap_remap
  import irqmap_pkg::*;
#(
  parameter int WR_W     = 16,
  parameter int SRC_W    = 9,
  parameter int SRC_LSB  = 0,
  parameter int NUM_LVL  = 8,
  parameter int MAX_IRQS = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_wr_en,
  input  logic [WR_W-1:0]      src_wr_data,
  input  logic [SRC_W-1:0]     glb_src_id,
  input  logic [IRQ_W-1:0]     irq_cmp,
  input  logic [IRQ_W-1:0]     irq_mask,
  input  logic                 rx_en,
  input  logic                 tx_en,
  output logic                 map_valid,
  output logic [IRQ_W-1:0]     lvl_base,
  output logic [IRQ_W-1:0]     msg_base,
  output logic [IRQ_W-1:0]     msg_count,
  output logic                 err_range,
  output logic                 err_cmp,
  output logic                 err_count
);

  localparam int CFG_W = 2*SRC_W + 2*IRQ_W + 2;

  logic [SRC_W-1:0] local_id;
  logic             wr_seen;
  logic [CFG_W-1:0] cfg_snap;
  logic             upd;
  map_res_t         res_calc, res_d, res_q;

  irqmap_srcid_reg #(
    .WR_W   (WR_W),
    .SRC_W  (SRC_W),
    .SRC_LSB(SRC_LSB)
  ) u_srcid (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (src_wr_en),
    .wr_data(src_wr_data),
    .src_id (local_id),
    .wr_seen(wr_seen)
  );

  assign cfg_snap = {local_id, glb_src_id, irq_cmp, irq_mask, rx_en, tx_en};

  irqmap_change_det #(
    .CFG_W(CFG_W)
  ) u_chg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_snap),
    .force_upd(wr_seen),
    .upd      (upd)
  );

  irqmap_calc #(
    .SRC_W   (SRC_W),
    .NUM_LVL (NUM_LVL),
    .MAX_IRQS(MAX_IRQS)
  ) u_calc (
    .local_id (local_id),
    .global_id(glb_src_id),
    .cmp      (irq_cmp),
    .mask     (irq_mask),
    .rx_en    (rx_en),
    .tx_en    (tx_en),
    .res      (res_calc)
  );

  // Output register loads only on a configuration change
  always_comb begin
    res_d = res_q;
    if (upd) begin
      res_d = res_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      res_q <= res_d;
    end
  end

  assign map_valid = res_q.valid;
  assign lvl_base  = res_q.lvl_base;
  assign msg_base  = res_q.msg_base;
  assign msg_count = res_q.msg_count;
  assign err_range = res_q.err_range;
  assign err_cmp   = res_q.err_cmp;
  assign err_count = res_q.err_count;

endmodule

// File: rtl/irqmap_remap_chk.sv
module irqmap_remap_chk #(
  parameter int SRC_W = 9,
  parameter int IRQ_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IRQ_W-1:0] irq_cmp,
  input logic [IRQ_W-1:0] irq_mask,
  input logic             rx_en,
  input logic             tx_en,
  input logic             map_valid,
  input logic [IRQ_W-1:0] lvl_base,
  input logic [IRQ_W-1:0] msg_base,
  input logic [IRQ_W-1:0] msg_count,
  input logic             err_range,
  input logic             err_cmp,
  input logic             err_count
);

  // R2: a valid mapping needs both enables on the previous cycle
  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> $past(rx_en && tx_en));

  // R2, R3: an invalid mapping leaves all other outputs at zero
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !map_valid |-> (lvl_base == '0 && msg_base == '0 && msg_count == '0 &&
                    !err_range && !err_cmp && !err_count));

  // R6: message window begins at the compare value
  assert_msg_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> (msg_base == $past(irq_cmp)));

  // R8: flag only when compare reaches outside the mask
  assert_cmp_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && err_cmp) |-> (($past(irq_cmp) & ~$past(irq_mask)) != '0));

  // R5: a zero mask leaves no room for message interrupts
  assert_zero_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && $past(irq_mask) == '0) |-> (msg_count == '0));

endmodule

bind irqmap_remap irqmap_remap_chk #(
  .SRC_W(SRC_W),
  .IRQ_W(irqmap_pkg::IRQ_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_cmp  (irq_cmp),
  .irq_mask (irq_mask),
  .rx_en    (rx_en),
  .tx_en    (tx_en),
  .map_valid(map_valid),
  .lvl_base (lvl_base),
  .msg_base (msg_base),
  .msg_count(msg_count),
  .err_range(err_range),
  .err_cmp  (err_cmp),
  .err_count(err_count)
);

// File: tb/test_irqmap_remap.sv
module test_irqmap_remap;

  logic        clk;
  logic        rst_n;
  logic        src_wr_en;
  logic [15:0] src_wr_data;
  logic [8:0]  glb_src_id;
  logic [18:0] irq_cmp;
  logic [18:0] irq_mask;
  logic        rx_en;
  logic        tx_en;
  logic        map_valid;
  logic [18:0] lvl_base;
  logic [18:0] msg_base;
  logic [18:0] msg_count;
  logic        err_range;
  logic        err_cmp;
  logic        err_count;

  int checks;
  int failures;
  bit done;

  irqmap_remap i_irqmap_remap (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_wr_en  (src_wr_en),
    .src_wr_data(src_wr_data),
    .glb_src_id (glb_src_id),
    .irq_cmp    (irq_cmp),
    .irq_mask   (irq_mask),
    .rx_en      (rx_en),
    .tx_en      (tx_en),
    .map_valid  (map_valid),
    .lvl_base   (lvl_base),
    .msg_base   (msg_base),
    .msg_count  (msg_count),
    .err_range  (err_range),
    .err_cmp    (err_cmp),
    .err_count  (err_count)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [15:0] wr;
    logic [8:0]  glb;
    logic [18:0] cmp;
    logic [18:0] mask;
    logic        rx;
    logic        tx;
    logic        ev;
    logic [18:0] lvl;
    logic [18:0] mb;
    logic [18:0] cnt;
    logic [2:0]  errs; // {range, cmp, count}
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TBL [NVEC] = '{
    // R5 R6 nominal: total 2048
    '{16'h0005, 9'd5,   19'h01000, 19'h7F800, 1'b1, 1'b1, 1'b1, 19'h01028, 19'h01000, 19'h007F8, 3'b000},
    // R4 upper write bits ignored
    '{16'hFE05, 9'd5,   19'h01000, 19'h7F800, 1'b1, 1'b1, 1'b1, 19'h01028, 19'h01000, 19'h007F8, 3'b000},
    // R3 ID mismatch
    '{16'h0005, 9'd6,   19'h01000, 19'h7F800, 1'b1, 1'b1, 1'b0, 19'h0,     19'h0,     19'h0,     3'b000},
    // R2 receive off
    '{16'h0005, 9'd5,   19'h01000, 19'h7F800, 1'b0, 1'b1, 1'b0, 19'h0,     19'h0,     19'h0,     3'b000},
    // R2 transmit off
    '{16'h0005, 9'd5,   19'h01000, 19'h7F800, 1'b1, 1'b0, 1'b0, 19'h0,     19'h0,     19'h0,     3'b000},
    // R8 compare outside mask
    '{16'h0005, 9'd5,   19'h00400, 19'h7F800, 1'b1, 1'b1, 1'b1, 19'h00428, 19'h00400, 19'h007F8, 3'b010},
    // R7 level block ends past total
    '{16'h0100, 9'd256, 19'h01000, 19'h7F800, 1'b1, 1'b1, 1'b1, 19'h01800, 19'h01000, 19'h007F8, 3'b100},
    // R9 total 8192 over limit
    '{16'h0005, 9'd5,   19'h02000, 19'h7E000, 1'b1, 1'b1, 1'b1, 19'h02028, 19'h02000, 19'h01FF8, 3'b001},
    // R5 R7 zero mask gives zero total
    '{16'h0005, 9'd5,   19'h00000, 19'h00000, 1'b1, 1'b1, 1'b1, 19'h00028, 19'h00000, 19'h00000, 3'b100},
    // R5 R7 total exactly 8, boundary not an error
    '{16'h0000, 9'd0,   19'h7FFF8, 19'h7FFF8, 1'b1, 1'b1, 1'b1, 19'h7FFF8, 19'h7FFF8, 19'h00000, 3'b000},
    // R6 level base wraps modulo 2^19
    '{16'h0001, 9'd1,   19'h7FFF8, 19'h7FFF8, 1'b1, 1'b1, 1'b1, 19'h00000, 19'h7FFF8, 19'h00000, 3'b100},
    // R5 total 1, count floors at 0
    '{16'h0000, 9'd0,   19'h00000, 19'h7FFFF, 1'b1, 1'b1, 1'b1, 19'h00000, 19'h00000, 19'h00000, 3'b100}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic ev, input logic [18:0] lvl,
                           input logic [18:0] mb, input logic [18:0] cnt,
                           input logic [2:0] errs);
    check({tag, " R3"}, "map_valid", 32'(map_valid), 32'(ev));
    check({tag, " R6"}, "lvl_base", 32'(lvl_base), 32'(lvl));
    check({tag, " R6"}, "msg_base", 32'(msg_base), 32'(mb));
    check({tag, " R5"}, "msg_count", 32'(msg_count), 32'(cnt));
    check({tag, " R7/R8/R9"}, "errors", 32'({err_range, err_cmp, err_count}), 32'(errs));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    src_wr_en = 1'b0;
    src_wr_data = 16'h0005;
    glb_src_id = 9'd5;
    irq_cmp = 19'h01000;
    irq_mask = 19'h7F800;
    rx_en = 1'b1;
    tx_en = 1'b1;

    // R1: outputs stay zero during reset despite a live configuration
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in reset", 1'b0, '0, '0, '0, 3'b000);
    rx_en = 1'b0;
    tx_en = 1'b0;
    irq_cmp = '0;
    irq_mask = '0;
    glb_src_id = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset", 1'b0, '0, '0, '0, 3'b000);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      src_wr_en = 1'b1;
      src_wr_data = TBL[i].wr;
      glb_src_id = TBL[i].glb;
      irq_cmp = TBL[i].cmp;
      irq_mask = TBL[i].mask;
      rx_en = TBL[i].rx;
      tx_en = TBL[i].tx;
      @(posedge clk);
      @(negedge clk);
      src_wr_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_all($sformatf("vec%0d", i), TBL[i].ev, TBL[i].lvl, TBL[i].mb,
                TBL[i].cnt, TBL[i].errs);
    end

    // Establish the nominal mapping
    @(negedge clk);
    src_wr_en = 1'b1;
    src_wr_data = 16'h0005;
    glb_src_id = 9'd5;
    irq_cmp = 19'h01000;
    irq_mask = 19'h7F800;
    rx_en = 1'b1;
    tx_en = 1'b1;
    @(negedge clk);
    src_wr_en = 1'b0;
    @(negedge clk);
    check("R10", "nominal valid", 32'(map_valid), 32'd1);

    // R10: port change visible after one edge
    irq_cmp = 19'h03000;
    @(negedge clk);
    check("R10", "msg_base one edge", 32'(msg_base), 32'h3000);
    check("R10", "lvl_base one edge", 32'(lvl_base), 32'h3028);

    // R10: outputs hold while nothing changes
    repeat (5) @(negedge clk);
    check("R10", "hold msg_base", 32'(msg_base), 32'h3000);
    check("R10", "hold valid", 32'(map_valid), 32'd1);

    // R10 R3: local write seen only after the second edge
    src_wr_en = 1'b1;
    src_wr_data = 16'h0006;
    @(negedge clk);
    src_wr_en = 1'b0;
    check("R10", "write first edge", 32'(map_valid), 32'd1);
    @(negedge clk);
    check("R3", "write second edge", 32'(map_valid), 32'd0);

    // R3: matching global ID restores the mapping one edge later
    glb_src_id = 9'd6;
    @(negedge clk);
    check("R3", "rematch valid", 32'(map_valid), 32'd1);
    check("R6", "rematch lvl_base", 32'(lvl_base), 32'h3030);

    // R4: a field value with only upper bits differing still matches
    src_wr_en = 1'b1;
    src_wr_data = 16'hAA06;
    @(negedge clk);
    src_wr_en = 1'b0;
    @(negedge clk);
    check("R4", "upper bits ignored", 32'(map_valid), 32'd1);

    // R1: reset mid-run clears the outputs
    rst_n = 1'b0;
    #1;
    check("R1", "async clear valid", 32'(map_valid), 32'd0);
    check("R1", "async clear base", 32'(msg_base), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end

endmodule